// File: doc/BRIEF.md
# Indirect Extended PHY Register Writer

This block turns a single host request into a complete write of one extended PHY register. It reaches that register through the two-register indirect window of the standard management interface. A control register at address 0xD selects a device and an access function. A companion register at address 0xE carries either an address or a data word, depending on the function last written to 0xD.

The host presents the PHY address, the device address, the 16-bit extended register address, the 16-bit data word and a divider select in one cycle. The block then sends four Clause 22 write frames on MDC/MDIO without further help from the host. The first frame sets the control register to address mode and the second loads the extended register address. The third sets the control register to data access with no increment, and the last sends the data word.

One busy flag covers all four frames. The host may start a new write only once that flag is low. The integrated PHY normally answers at PHY address 0 with device address 0x1F; the host supplies both values on every request.

Top module: `xmw_writer`

## Requirements
- R1: An accepted request produces exactly four write frames, in this order:
  - register 0xD with the address-mode control word;
  - register 0xE with the extended register address;
  - register 0xD with the data-mode control word;
  - register 0xE with the data word.
- R2: Each frame is 64 bits, sent most significant bit first:
  - 32 ones;
  - start bits 01;
  - write opcode 01;
  - the 5-bit PHY address;
  - the 5-bit register address;
  - turnaround 10;
  - the 16 data bits.
- R3: The control word holds the function code in bits 15:14 and the device address in bits 4:0, with bits 13:5 zero. The function code is 00 for address mode and 01 for data access with no increment.
- R4: `busy` is high in the clock cycle after a request is accepted. It stays high until the final data bit has been sampled, and falls at the MDC falling edge that ends the last frame.
- R5: MDIO changes only while MDC is low, so it is stable at every MDC rising edge and throughout each MDC high phase.
- R6: `mdio_oe` is high while a write is in progress and low when idle.
- R7: `clk_sel` selects the MDC period in system clock cycles: 0 gives 16, 1 gives 26, 2 gives 42, 3 gives 62 and 4 gives 102. Codes 5 to 7 give 102. MDC is high for half of each period.
- R8: A request that arrives while `busy` is high is ignored and leaves the frames in progress unchanged.
- R9: MDC is held low while the block is idle.
- R10: After reset, `busy`, `mdio_oe` and `mdc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_phy | input | 5 | PHY address for all four frames |
| req_dev | input | 5 | Device address placed in the control word |
| req_addr | input | 16 | Extended register address |
| req_data | input | 16 | Data to write to the extended register |
| clk_sel | input | 3 | MDC divider select |
| busy | output | 1 | Write sequence in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |

## Verification
The bound checker checks the cycle-level rules on every cycle. These are MDIO stability while MDC is high, MDC held low when idle, `busy` rising only after a request, and MDC falling as each frame ends. Frame content and order, control-word layout, and the MDC period for each divider code are checked by the bench. So is the rejection of requests made while busy. The bench rebuilds the 256 bits sampled at MDC rising edges from random and directed requests, and compares them with a sequence it computes itself.

// File: rtl/xmw_pkg.sv
package xmw_pkg;
  localparam int FRAME_BITS = 64;
  localparam int NUM_FRAMES = 4;
  localparam int RATIO_W    = 7;
  localparam logic [4:0] CTRL_REG = 5'hD;
  localparam logic [4:0] WIN_REG  = 5'hE;
  localparam logic [1:0] FN_ADDR  = 2'b00;
  localparam logic [1:0] FN_DATA  = 2'b01;

  function automatic logic [RATIO_W-1:0] div_ratio(input logic [2:0] sel);
    case (sel)
      3'd0:    return RATIO_W'(16);
      3'd1:    return RATIO_W'(26);
      3'd2:    return RATIO_W'(42);
      3'd3:    return RATIO_W'(62);
      default: return RATIO_W'(102);
    endcase
  endfunction

  function automatic logic [15:0] ctrl_word(input logic [1:0] fn, input logic [4:0] dev);
    return {fn, 9'b0, dev};
  endfunction

  function automatic logic [FRAME_BITS-1:0] write_frame(input logic [4:0] phy,
                                                       input logic [4:0] regad,
                                                       input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, phy, regad, 2'b10, d};
  endfunction
endpackage

// File: rtl/xmw_clkgen.sv
module xmw_clkgen
  import xmw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               mdc,
  output logic               rise_tick,
  output logic               fall_tick
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] half;

  assign half      = ratio >> 1;
  assign rise_tick = run && (cnt == half - 1'b1);
  assign fall_tick = run && (cnt == ratio - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (fall_tick) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (rise_tick) mdc <= 1'b1;
    end
  end
endmodule

// File: rtl/xmw_shifter.sv
module xmw_shifter
  import xmw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] word,
  input  logic                  fall_tick,
  output logic                  mdio_o,
  output logic                  frame_done
);
  localparam int CW = $clog2(FRAME_BITS);
  logic [FRAME_BITS-1:0] shreg;
  logic [CW-1:0]         bitcnt;
  logic                  active;

  assign mdio_o     = shreg[FRAME_BITS-1];
  assign frame_done = active && fall_tick && (bitcnt == CW'(FRAME_BITS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
      active <= 1'b0;
    end else if (load) begin
      shreg  <= word;
      bitcnt <= '0;
      active <= 1'b1;
    end else if (active && fall_tick) begin
      if (frame_done) begin
        active <= 1'b0;
      end else begin
        shreg  <= {shreg[FRAME_BITS-2:0], 1'b0};
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xmw_seq.sv
module xmw_seq
  import xmw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [4:0]            req_phy,
  input  logic [4:0]            req_dev,
  input  logic [15:0]           req_addr,
  input  logic [15:0]           req_data,
  input  logic [2:0]            clk_sel,
  input  logic                  frame_done,
  output logic                  busy,
  output logic                  load,
  output logic [FRAME_BITS-1:0] word,
  output logic [RATIO_W-1:0]    ratio,
  output logic                  accept
);
  localparam int IW = $clog2(NUM_FRAMES);
  logic [IW-1:0] idx;
  logic [4:0]    phy_q, dev_q;
  logic [15:0]   addr_q, data_q;
  logic [2:0]    sel_q;
  logic [4:0]    regad;
  logic [15:0]   payload;

  assign accept = req_valid && !busy;
  assign ratio  = div_ratio(sel_q);

  always_comb begin
    case (idx)
      IW'(0):  begin regad = CTRL_REG; payload = ctrl_word(FN_ADDR, dev_q); end
      IW'(1):  begin regad = WIN_REG;  payload = addr_q;                   end
      IW'(2):  begin regad = CTRL_REG; payload = ctrl_word(FN_DATA, dev_q); end
      default: begin regad = WIN_REG;  payload = data_q;                   end
    endcase
    word = write_frame(phy_q, regad, payload);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      load   <= 1'b0;
      idx    <= '0;
      phy_q  <= '0;
      dev_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      sel_q  <= '0;
    end else begin
      load <= 1'b0;
      if (accept) begin
        phy_q  <= req_phy;
        dev_q  <= req_dev;
        addr_q <= req_addr;
        data_q <= req_data;
        sel_q  <= clk_sel;
        idx    <= '0;
        busy   <= 1'b1;
        load   <= 1'b1;
      end else if (busy && frame_done) begin
        if (idx == IW'(NUM_FRAMES-1)) begin
          busy <= 1'b0;
        end else begin
          idx  <= idx + 1'b1;
          load <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xmw_writer.sv
module xmw_writer
  import xmw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_dev,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_data,
  input  logic [2:0]  clk_sel,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic                  accept;
  logic                  load;
  logic [FRAME_BITS-1:0] word;
  logic [RATIO_W-1:0]    ratio;
  logic                  rise_tick, fall_tick;
  logic                  frame_done;

  xmw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phy(req_phy),
    .req_dev(req_dev), .req_addr(req_addr), .req_data(req_data),
    .clk_sel(clk_sel), .frame_done(frame_done), .busy(busy), .load(load),
    .word(word), .ratio(ratio), .accept(accept)
  );

  xmw_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .ratio(ratio), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  xmw_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .load(load), .word(word),
    .fall_tick(fall_tick), .mdio_o(mdio_o), .frame_done(frame_done)
  );

  assign mdio_oe = busy;
endmodule

// File: rtl/xmw_writer_chk.sv
module xmw_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic mdc,
  input logic mdio_o,
  input logic load,
  input logic frame_done
);
  // R5: data holds while the management clock stays high
  p_mdio_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  // R9: clock parked low when idle
  p_mdc_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R4: busy rises only in response to a request
  p_busy_from_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R4: a frame ends on a falling clock edge
  p_frame_end_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !mdc);

  // R1: frames are loaded only inside a sequence
  p_load_in_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> busy);
endmodule

bind xmw_writer xmw_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .mdc(mdc),
  .mdio_o(mdio_o), .load(load), .frame_done(frame_done)
);

// File: tb/sim_xmw_writer.sv
`timescale 1ns/1ps
module sim_xmw_writer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [4:0] req_phy = '0, req_dev = '0;
  logic [15:0] req_addr = '0, req_data = '0;
  logic [2:0] clk_sel = '0;
  logic busy, mdc, mdio_o, mdio_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  xmw_writer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phy(req_phy),
    .req_dev(req_dev), .req_addr(req_addr), .req_data(req_data),
    .clk_sel(clk_sel), .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // capture of MDIO at every MDC rising edge
  logic [255:0] cap;
  int  cap_n = 0;
  time rise_t0, rise_t1, fall_t0;
  int  n_fall = 0;
  logic busy_at_last;

  always @(posedge mdc) begin
    if (cap_n == 0) rise_t0 = $time;
    if (cap_n == 1) rise_t1 = $time;
    if (cap_n < 256) begin
      cap[255 - cap_n] = mdio_o;
      if (cap_n == 255) busy_at_last = busy;
      cap_n++;
    end
  end
  always @(negedge mdc) begin
    if (n_fall == 0) fall_t0 = $time;
    n_fall++;
  end

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=190000", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_ratio(input logic [2:0] s);
    int tbl[5] = '{16, 26, 42, 62, 102};
    return (s < 5) ? tbl[s] : 102;
  endfunction

  function automatic logic [63:0] frame_of(input logic [4:0] p, input logic [4:0] r,
                                           input logic [15:0] d);
    logic [63:0] f = '1;
    f[31:30] = 2'b01;
    f[29:28] = 2'b01;
    f[27:23] = p;
    f[22:18] = r;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  function automatic logic [255:0] exp_seq(input logic [4:0] p, input logic [4:0] dv,
                                           input logic [15:0] a, input logic [15:0] d);
    logic [15:0] c_addr, c_data;
    c_addr = '0; c_addr[4:0] = dv; c_addr[15:14] = 2'b00;   // R3
    c_data = '0; c_data[4:0] = dv; c_data[15:14] = 2'b01;   // R3
    return {frame_of(p, 5'hD, c_addr), frame_of(p, 5'hE, a),
            frame_of(p, 5'hD, c_data), frame_of(p, 5'hE, d)};
  endfunction

  task automatic run_req(input logic [4:0] p, input logic [4:0] dv, input logic [15:0] a,
                         input logic [15:0] d, input logic [2:0] s, input bit inject);
    logic [255:0] exp;
    int r;
    exp = exp_seq(p, dv, a, d);
    r = exp_ratio(s);
    cap_n = 0; n_fall = 0;
    @(negedge clk);
    req_valid = 1'b1; req_phy = p; req_dev = dv; req_addr = a; req_data = d; clk_sel = s;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R4", "busy after accept", 256'(busy), 256'(1));
    repeat (r * 3) @(negedge clk);
    chk(mdio_oe === 1'b1, "R6", "oe while busy", 256'(mdio_oe), 256'(1));
    if (inject) begin
      // R8: a second request while busy must be ignored
      req_valid = 1'b1; req_phy = ~p; req_dev = ~dv; req_addr = ~a; req_data = ~d;
      clk_sel = 3'd0;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(cap_n == 256, "R1", "bit count", 256'(cap_n), 256'(256));
    chk(busy_at_last === 1'b1, "R4", "busy at final bit", 256'(busy_at_last), 256'(1));
    chk(cap == exp, inject ? "R8" : "R1", "frame bits", cap, exp);
    chk(rise_t1 - rise_t0 == time'(r * 4), "R7", "mdc period ns",
        256'(rise_t1 - rise_t0), 256'(r * 4));
    chk(fall_t0 - rise_t0 == time'((r / 2) * 4), "R7", "mdc high ns",
        256'(fall_t0 - rise_t0), 256'((r / 2) * 4));
    chk(mdio_oe === 1'b0, "R6", "oe idle", 256'(mdio_oe), 256'(0));
    repeat (20) @(negedge clk);
    chk(mdc === 1'b0 && cap_n == 256, "R9", "mdc idle low", 256'(mdc), 256'(0));
  endtask

  initial begin
    logic [15:0] a, d;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R10", "busy in reset", 256'(busy), 256'(0));
    chk(mdio_oe === 1'b0, "R10", "oe in reset", 256'(mdio_oe), 256'(0));
    chk(mdc === 1'b0, "R10", "mdc in reset", 256'(mdc), 256'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // directed: integrated PHY defaults, R2 framing
    run_req(5'h00, 5'h1F, 16'h0123, 16'hBEEF, 3'd0, 1'b0);
    // directed: request ignored while busy
    run_req(5'h00, 5'h1F, 16'h8001, 16'h7FFE, 3'd1, 1'b1);
    // directed: largest divider and a reserved code
    run_req(5'h1F, 5'h00, 16'hFFFF, 16'h0000, 3'd4, 1'b0);
    run_req(5'h0A, 5'h15, 16'h5A5A, 16'hA5A5, 3'd6, 1'b0);
    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 5; i++) begin
      a = 16'($urandom);
      d = 16'($urandom);
      run_req(5'($urandom), 5'($urandom), a, d, 3'($urandom % 4), 1'b0);
    end
    report();
    $finish;
  end
endmodule